// File: doc/BRIEF.md
# Error-Count Threshold Alarm Unit

This block keeps a running tally of two kinds of receive errors: header-check errors and bit-interleaved parity (BIP) errors. Each kind has its own 8-bit saturating counter and its own programmable threshold. When a counter steps onto its threshold value, a sticky alarm bit is latched. The alarm stays set until software reads the alarm status register.

A separate enable register masks each alarm bit before the alarms are combined into one registered interrupt line. Error detection happens upstream, and the block sees only one-cycle error pulses. The surrounding logic may zero both counters at any time through a synchronous clear input, for example at the end of a measurement interval.

Register access uses a one-bit select: 0 selects the alarm status register and 1 selects the enable register. Read data is always driven for the selected register. The read strobe is needed only to clear the alarm status on read.

Top module: `errthr_top`

## Requirements
- R1: After reset, the alarm status reads 0x00, the enable register reads 0x00 and `irq` is 0.
- R2: Each error counter increases by one per error pulse and saturates at 255 without wrapping, so one long burst of pulses latches the alarm at most once.
- R3: An alarm bit is set at the clock edge where its counter increments onto a value equal to its threshold. Status bit 1 is the header-check alarm, bit 0 is the BIP alarm, and bits 7:2 read as zero.
- R4: A set alarm bit stays 1 until a read strobe with select 0 is accepted, which clears it at that edge. The counter falling back does not clear it.
- R5: A threshold of zero never sets its alarm, whatever the number of error pulses.
- R6: When a threshold-equal event coincides with a status read strobe, the alarm bit is 1 after that edge.
- R7: `irq` is registered. One cycle after any cycle, it equals the OR over both bits of (alarm AND enable) from that cycle. Enable bit 1 masks the header-check alarm and enable bit 0 masks the BIP alarm.
- R8: A write with select 1 loads `reg_wdata[1:0]` into the enable register, which reads back with bits 7:2 as zero. A write with select 0 does not change the alarm status.
- R9: The synchronous counter clear sets both counters to zero and takes priority over an error pulse in the same cycle. After a clear, the alarm fires only after a full threshold's worth of new pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_clr | input | 1 | Synchronous clear of both error counters |
| hdr_err | input | 1 | One pulse per header-check error |
| bip_err | input | 1 | One pulse per BIP error |
| hdr_thresh | input | 8 | Header-check alarm threshold (0 disables) |
| bip_thresh | input | 8 | BIP alarm threshold (0 disables) |
| reg_sel | input | 1 | 0 = alarm status, 1 = enable register |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears status when select is 0) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Registered masked interrupt |

## Verification
The assertions check several rules on every cycle: single-step increments, saturation at 255, priority of the counter clear, alarm stickiness unless a status read is accepted, priority of a set over a coincident clear, the zero-threshold suppression, and the one-cycle relation between `irq` and the masked alarms. Only the bench scenarios show the end-to-end behaviour. These include the exact pulse count at which each alarm appears at the register port, the absence of a second alarm after saturation, enable read-back and ignored status writes, and the mapping of enable bits to alarm bits. The bench checks these against a cycle model under directed sequences and a long random run.

// File: rtl/errthr_pkg.sv
package errthr_pkg;
    localparam int CNT_W   = 8;
    localparam int DATA_W  = 8;
    localparam int NUM_ALM = 2;

    // alarm bit positions (software decodes these)
    typedef enum int {
        ALM_BIP = 0,
        ALM_HDR = 1
    } alm_idx_e;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic             wr;
        logic             rd;
        reg_sel_e         sel;
        logic [DATA_W-1:0] wdata;
    } reg_req_t;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
    endfunction
endpackage

// File: rtl/errthr_counter.sv
module errthr_counter
    import errthr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         pulse,
    input  logic [W-1:0] thresh,
    output logic         hit
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic         can_inc;

    assign can_inc = pulse && !clr && (cnt_q != MAXV);
    assign hit     = can_inc && (thresh != '0) && ((cnt_q + 1'b1) == thresh);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (pulse)
            cnt_q <= sat_inc(cnt_q);
    end

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        can_inc |=> cnt_q == W'($past(cnt_q) + 1'b1));
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == MAXV && !clr) |=> cnt_q == MAXV);
    p_clr_wins_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt_q == '0);
    p_zero_thr_r5: assert property (@(posedge clk) disable iff (rst)
        (thresh == '0) |-> !hit);
endmodule

// File: rtl/errthr_alarm_bank.sv
module errthr_alarm_bank
    import errthr_pkg::*;
#(
    parameter int N = NUM_ALM
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic         rd_clr,
    output logic [N-1:0] alarm
);
    logic [N-1:0] alarm_q;

    always_ff @(posedge clk) begin
        if (rst)
            alarm_q <= '0;
        else
            alarm_q <= (rd_clr ? '0 : alarm_q) | set_vec;
    end

    assign alarm = alarm_q;

    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        !rd_clr |=> ((alarm_q & $past(alarm_q)) == $past(alarm_q)));

    for (genvar i = 0; i < N; i++) begin : g_chk
        p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
            set_vec[i] |=> alarm_q[i]);
    end
endmodule

// File: rtl/errthr_regs.sv
module errthr_regs
    import errthr_pkg::*;
#(
    parameter int N  = NUM_ALM,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  reg_req_t      req,
    input  logic [N-1:0]  alarm,
    output logic [DW-1:0] rdata,
    output logic          rd_clr,
    output logic          irq
);
    logic [N-1:0] en_q;
    logic         irq_q;
    logic         wdata_unused;

    assign wdata_unused = ^req.wdata[DW-1:N];
    assign rd_clr       = req.rd && (req.sel == SEL_STATUS);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            if (req.wr && req.sel == SEL_ENABLE)
                en_q <= req.wdata[N-1:0];
            irq_q <= |(alarm & en_q);
        end
    end

    always_comb begin
        rdata = '0;
        if (req.sel == SEL_ENABLE)
            rdata[N-1:0] = en_q;
        else
            rdata[N-1:0] = alarm;
    end

    assign irq = irq_q;

    p_irq_follow_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq_q == |($past(alarm) & $past(en_q)));
    p_en_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && req.sel == SEL_ENABLE) |=> $stable(en_q));

    always_comb begin
        if (!rst) begin
            a_upper_zero_r3: assert (rdata[DW-1:N] == '0);
        end
    end
endmodule

// File: rtl/errthr_top.sv
module errthr_top
    import errthr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_clr,
    input  logic          hdr_err,
    input  logic          bip_err,
    input  logic [CW-1:0] hdr_thresh,
    input  logic [CW-1:0] bip_thresh,
    input  logic          reg_sel,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq
);
    localparam int N = NUM_ALM;

    logic [N-1:0]  pulses;
    logic [CW-1:0] thr [N];
    logic [N-1:0]  hits;
    logic [N-1:0]  alarm;
    logic          rd_clr;
    reg_req_t      req;

    always_comb begin
        pulses          = '0;
        pulses[ALM_HDR] = hdr_err;
        pulses[ALM_BIP] = bip_err;
        thr[ALM_HDR]    = hdr_thresh;
        thr[ALM_BIP]    = bip_thresh;
        req.wr          = reg_wr;
        req.rd          = reg_rd;
        req.sel         = reg_sel_e'(reg_sel);
        req.wdata       = reg_wdata;
    end

    for (genvar i = 0; i < N; i++) begin : g_cnt
        errthr_counter #(.W(CW)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .clr    (cnt_clr),
            .pulse  (pulses[i]),
            .thresh (thr[i]),
            .hit    (hits[i])
        );
    end

    errthr_alarm_bank #(.N(N)) u_alm (
        .clk     (clk),
        .rst     (rst),
        .set_vec (hits),
        .rd_clr  (rd_clr),
        .alarm   (alarm)
    );

    errthr_regs #(.N(N), .DW(DW)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .alarm  (alarm),
        .rdata  (reg_rdata),
        .rd_clr (rd_clr),
        .irq    (irq)
    );
endmodule

// File: tb/sim_errthr_top.sv
`timescale 1ns/1ps
module sim_errthr_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_clr = 1'b0, hdr_err = 1'b0, bip_err = 1'b0;
    logic [7:0] hdr_thresh = 8'd0, bip_thresh = 8'd0;
    logic       reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model
    int       m_ch, m_cb;
    bit [1:0] m_alm, m_en;
    bit       m_irq;

    always #10 clk = ~clk;

    errthr_top u0 (
        .clk(clk), .rst(rst), .cnt_clr(cnt_clr), .hdr_err(hdr_err), .bip_err(bip_err),
        .hdr_thresh(hdr_thresh), .bip_thresh(bip_thresh), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic bit fires(int c, int thr, bit p, bit clr);
        return p && !clr && c != 255 && thr != 0 && (c + 1) == thr;
    endfunction

    function automatic int next_cnt(int c, bit p, bit clr);
        if (clr) return 0;
        if (p && c != 255) return c + 1;
        return c;
    endfunction

    function automatic bit [7:0] exp_rdata(bit sel);
        return sel ? {6'b0, m_en} : {6'b0, m_alm};
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ch = 0; m_cb = 0; m_alm = 0; m_en = 0; m_irq = 0;
    endtask

    // one cycle: drive at negedge, compare, then advance the model at posedge
    task automatic step(string tag, bit hp, bit bp, bit clr, bit rd, bit wr, bit sel, bit [7:0] wd);
        bit       eh, eb;
        bit [1:0] na;
        @(negedge clk);
        hdr_err = hp; bip_err = bp; cnt_clr = clr;
        reg_rd = rd; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        #1;
        check(tag, "rdata", reg_rdata, exp_rdata(sel));
        check("R7", "irq", irq, m_irq);
        @(posedge clk);
        eh = fires(m_ch, hdr_thresh, hp, clr);
        eb = fires(m_cb, bip_thresh, bp, clr);
        na = ((rd && !sel) ? 2'b00 : m_alm) | {eh, eb};
        m_irq = |(m_alm & m_en);
        if (wr && sel) m_en = wd[1:0];
        m_alm = na;
        m_ch = next_cnt(m_ch, hp, clr);
        m_cb = next_cnt(m_cb, bp, clr);
    endtask

    task automatic idle(string tag, int n, bit sel);
        for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, sel, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: reset values
        idle("R1", 2, 0);
        idle("R1", 1, 1);

        // R8: enable read-back, upper bits zero; status write ignored
        step("R8", 0, 0, 0, 0, 1, 1, 8'hFF);
        idle("R8", 1, 1);
        step("R8", 0, 0, 0, 0, 1, 0, 8'hFF);
        idle("R8", 1, 0);

        // R3: header alarm on exactly the 3rd pulse, BIP on the 5th
        hdr_thresh = 8'd3; bip_thresh = 8'd5;
        for (int i = 0; i < 5; i++) step("R3", i < 3, 1, 0, 0, 0, 0, 8'h00);
        // R4: sticky while idle, then read clears
        idle("R4", 4, 0);
        step("R4", 0, 0, 0, 1, 0, 0, 8'h00);
        idle("R4", 2, 0);

        // R7: enable mapping, only BIP enabled
        step("R7", 0, 0, 0, 0, 1, 1, 8'h01);
        step("R9", 0, 0, 1, 0, 0, 0, 8'h00);
        for (int i = 0; i < 3; i++) step("R7", 1, 0, 0, 0, 0, 0, 8'h00);
        idle("R7", 3, 0);
        step("R7", 0, 0, 0, 1, 0, 0, 8'h00);

        // R9: clear beats a coincident pulse
        step("R9", 1, 1, 1, 0, 0, 0, 8'h00);
        for (int i = 0; i < 3; i++) step("R9", 1, 0, 0, 0, 0, 0, 8'h00);
        step("R9", 0, 0, 0, 1, 0, 0, 8'h00);

        // R6: set coincides with status read
        step("R6", 0, 0, 1, 0, 1, 1, 8'h03);
        step("R6", 1, 0, 0, 0, 0, 0, 8'h00);
        step("R6", 1, 0, 0, 0, 0, 0, 8'h00);
        step("R6", 1, 0, 0, 1, 0, 0, 8'h00);
        idle("R6", 2, 0);
        step("R6", 0, 0, 0, 1, 0, 0, 8'h00);

        // R5: zero threshold never fires
        hdr_thresh = 8'd0; bip_thresh = 8'd0;
        step("R5", 0, 0, 1, 0, 0, 0, 8'h00);
        for (int i = 0; i < 300; i++) step("R5", 1, 1, 0, 0, 0, 0, 8'h00);
        idle("R5", 2, 0);

        // R2: saturation, no second alarm after a long burst
        hdr_thresh = 8'd4; bip_thresh = 8'd255;
        step("R2", 0, 0, 1, 0, 0, 0, 8'h00);
        for (int i = 0; i < 10; i++) step("R2", 1, 1, 0, 0, 0, 0, 8'h00);
        step("R2", 1, 1, 0, 1, 0, 0, 8'h00);
        for (int i = 0; i < 300; i++) step("R2", 1, 1, 0, i == 250, 0, 0, 8'h00);
        idle("R2", 2, 0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if (i % 200 == 0) begin
                hdr_thresh = ($urandom % 5 == 0) ? 8'd0 : 8'($urandom % 12 + 1);
                bip_thresh = ($urandom % 5 == 0) ? 8'd0 : 8'($urandom % 12 + 1);
            end
            step("R3", $urandom % 3 == 0, $urandom % 3 == 0, $urandom % 40 == 0,
                 $urandom % 9 == 0, $urandom % 20 == 0, $urandom % 2 == 1, 8'($urandom));
        end
        idle("R7", 3, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule